// File: doc/BRIEF.md
# Island and Control Symbol Encoder

This block produces, in every pixel period that lies outside active video, the 10-bit line symbol for each of three serial-link channels, and packs the three symbols into one 32-bit word for a downstream streaming engine. A two-bit period code chooses what is sent. Blanking control words carry the two sync bits. Preamble words announce an upcoming data island. Guard-band symbols frame the island. Inside the island, each channel sends a 4-bit-to-10-bit code taken from the island data.

Inside an island there is no separate control word for sync. The horizontal and vertical sync bits become the two low bits of the 4-bit value coded on channel 0. Each sync state can therefore appear as four different symbols, and the island data picks which one. Sync must not move while a guard band is on the wire, so the block raises a flag whenever it sees a sync transition in a guard-band period. The output word and the flag are registered and carry one cycle of latency.

Top module: `island_symbol_gen`

## Requirements
- R1: While reset is asserted and after it, until the first rising edge with reset released, `word_out` is all zeros and `guard_err` is 0.
- R2: Period code 0 means control. Channel 0 sends the control word picked by {vsync,hsync}: 00→1101010100, 01→0010101011, 10→0101010100, 11→1010101011. Channels 1 and 2 both send 1101010100.
- R3: Period code 1 means preamble. Channel 0 sends the same sync control word as in R2. Channels 1 and 2 both send 0010101011.
- R4: Period code 2 means guard band. Channels 1 and 2 send 0100110011. Channel 0 sends the 4-bit code of {1,1,vsync,hsync}, with vsync in bit 1 and hsync in bit 0.
- R5: Period code 3 means island data. Channel 1 sends the code of `isl_ch1` and channel 2 sends the code of `isl_ch2`. Channel 0 sends the code of {isl_ch0[1], isl_ch0[0], vsync, hsync}, with isl_ch0 in bits 3:2.
- R6: The 4-bit code maps its 16 values to distinct 10-bit symbols: 0→1010011100, 1→1001100011, 2→1011100100, 3→1011100010, 4→0101110001, 5→0100011110, 6→0110001110, 7→0100111100, 8→1011001100, 9→0100111001, 10→0110011100, 11→1011000110, 12→1010001110, 13→1001110001, 14→0101100011, 15→1011000011.
- R7: `word_out` holds channel 0 in bits 9:0, channel 1 in bits 19:10 and channel 2 in bits 29:20, and bits 31:30 are 0. The word appears one clock after its inputs are sampled.
- R8: `guard_err` is 1 for exactly the output cycle of a guard-band period whose {vsync,hsync} differs from the value sampled one clock earlier. A sync change in any other period leaves it at 0.
- R9: The island nibble inputs have no effect on the output word in control, preamble and guard-band periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period | input | 2 | 0 control, 1 preamble, 2 guard band, 3 island data |
| hsync | input | 1 | Horizontal sync level |
| vsync | input | 1 | Vertical sync level |
| isl_ch0 | input | 2 | Island data bits for channel 0 (code bits 3:2) |
| isl_ch1 | input | 4 | Island data nibble for channel 1 |
| isl_ch2 | input | 4 | Island data nibble for channel 2 |
| word_out | output | 32 | Packed three-channel symbol word, registered |
| guard_err | output | 1 | Sync changed during a guard-band period, registered |

## Verification
Two functions can act in the same cycle. One is guard-band encoding, which folds the new sync state into the channel 0 code. The other is the sync-change flag. A guard-band task drives a sync transition into a guard period. It then checks that the flag and the channel 0 symbol carrying the new sync value leave the block in the same output word. The bench also sends sync changes in control and island-data periods, and a guard period with steady sync, to confirm that the flag stays low in those cases while the symbols still follow the sync.

// File: rtl/isg_pkg.sv
package isg_pkg;

  localparam int SYM_W = 10;
  localparam int NCH   = 3;

  typedef enum logic [1:0] {
    PER_CTRL  = 2'd0,
    PER_PRE   = 2'd1,
    PER_GUARD = 2'd2,
    PER_DATA  = 2'd3
  } period_e;

  localparam logic [SYM_W-1:0] GB_WORD = 10'b0100110011;

  function automatic logic [SYM_W-1:0] ctl_word(input logic [1:0] c);
    case (c)
      2'b00:   ctl_word = 10'b1101010100;
      2'b01:   ctl_word = 10'b0010101011;
      2'b10:   ctl_word = 10'b0101010100;
      default: ctl_word = 10'b1010101011;
    endcase
  endfunction

  function automatic logic [SYM_W-1:0] terc4(input logic [3:0] n);
    case (n)
      4'd0:    terc4 = 10'b1010011100;
      4'd1:    terc4 = 10'b1001100011;
      4'd2:    terc4 = 10'b1011100100;
      4'd3:    terc4 = 10'b1011100010;
      4'd4:    terc4 = 10'b0101110001;
      4'd5:    terc4 = 10'b0100011110;
      4'd6:    terc4 = 10'b0110001110;
      4'd7:    terc4 = 10'b0100111100;
      4'd8:    terc4 = 10'b1011001100;
      4'd9:    terc4 = 10'b0100111001;
      4'd10:   terc4 = 10'b0110011100;
      4'd11:   terc4 = 10'b1011000110;
      4'd12:   terc4 = 10'b1010001110;
      4'd13:   terc4 = 10'b1001110001;
      4'd14:   terc4 = 10'b0101100011;
      default: terc4 = 10'b1011000011;
    endcase
  endfunction

endpackage

// File: rtl/isg_chan_enc.sv
module isg_chan_enc
  import isg_pkg::*;
#(
  parameter bit IS_CH0 = 1'b0
) (
  input  logic [1:0]       period,
  input  logic [1:0]       ctl,
  input  logic [3:0]       nib,
  output logic [SYM_W-1:0] sym
);

  always_comb begin
    case (period)
      PER_CTRL, PER_PRE: sym = ctl_word(ctl);
      PER_GUARD:         sym = IS_CH0 ? terc4(nib) : GB_WORD;
      default:           sym = terc4(nib);
    endcase
  end

endmodule

// File: rtl/isg_guard_check.sv
module isg_guard_check (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       is_guard,
  input  logic [1:0] sync,
  output logic       err_q
);

  logic [1:0] prev_q, prev_d;
  logic       seen_q, seen_d;
  logic       err_d;

  always_comb begin
    prev_d = sync;
    seen_d = 1'b1;
    err_d  = is_guard && seen_q && (sync != prev_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 2'b00;
      seen_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      prev_q <= prev_d;
      seen_q <= seen_d;
      err_q  <= err_d;
    end
  end

  AST_ERR_ONLY_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $past(is_guard)); // R8

  AST_ERR_NEEDS_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && is_guard && $stable(sync)) |=> !err_q); // R8

endmodule

// File: rtl/island_symbol_gen.sv
module island_symbol_gen
  import isg_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        period,
  input  logic              hsync,
  input  logic              vsync,
  input  logic [1:0]        isl_ch0,
  input  logic [3:0]        isl_ch1,
  input  logic [3:0]        isl_ch2,
  output logic [WORD_W-1:0] word_out,
  output logic              guard_err
);

  localparam int USED_W = NCH * SYM_W;
  localparam int PAD_W  = WORD_W - USED_W;

  logic [1:0]                  sync;
  logic [1:0]                  ctl_a [NCH];
  logic [3:0]                  nib_a [NCH];
  logic [NCH-1:0][SYM_W-1:0]   sym_a;
  logic [WORD_W-1:0]           word_d, word_q;
  logic                        live_q;

  always_comb begin
    sync = {vsync, hsync};
    ctl_a[0] = sync;
    nib_a[0] = (period == PER_GUARD) ? {2'b11, sync} : {isl_ch0, sync};
    ctl_a[1] = (period == PER_PRE) ? 2'b01 : 2'b00;
    ctl_a[2] = (period == PER_PRE) ? 2'b01 : 2'b00;
    nib_a[1] = isl_ch1;
    nib_a[2] = isl_ch2;
  end

  for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
    isg_chan_enc #(.IS_CH0(gi == 0)) u_enc (
      .period (period),
      .ctl    (ctl_a[gi]),
      .nib    (nib_a[gi]),
      .sym    (sym_a[gi])
    );
  end

  always_comb begin
    word_d = {{PAD_W{1'b0}}, sym_a};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      live_q <= 1'b0;
    end else begin
      word_q <= word_d;
      live_q <= 1'b1;
    end
  end

  isg_guard_check u_gchk (
    .clk      (clk),
    .rst_n    (rst_n),
    .is_guard (period == PER_GUARD),
    .sync     (sync),
    .err_q    (guard_err)
  );

  assign word_out = word_q;

  AST_CTRL_SIDE_CH: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $past(period) == PER_CTRL) |->
      (word_q[19:10] == 10'b1101010100 && word_q[29:20] == 10'b1101010100)); // R2

  AST_PRE_SIDE_CH: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $past(period) == PER_PRE) |->
      (word_q[19:10] == 10'b0010101011 && word_q[29:20] == 10'b0010101011)); // R3

  AST_GUARD_SIDE_CH: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $past(period) == PER_GUARD) |->
      (word_q[19:10] == GB_WORD && word_q[29:20] == GB_WORD)); // R4

  AST_ISLAND_NOT_CTL: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $past(period[1])) |->
      (word_q[9:0] != 10'b1101010100 && word_q[9:0] != 10'b0010101011 &&
       word_q[9:0] != 10'b0101010100 && word_q[9:0] != 10'b1010101011)); // R5

  AST_PAD_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(word_q[WORD_W-1:USED_W])); // R7

endmodule

// File: tb/sim_island_symbol_gen.sv
module sim_island_symbol_gen;

  logic        clk;
  logic        rst_n;
  logic [1:0]  period;
  logic        hsync, vsync;
  logic [1:0]  isl_ch0;
  logic [3:0]  isl_ch1, isl_ch2;
  logic [31:0] word_out;
  logic        guard_err;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  island_symbol_gen u0 (
    .clk(clk), .rst_n(rst_n), .period(period), .hsync(hsync), .vsync(vsync),
    .isl_ch0(isl_ch0), .isl_ch1(isl_ch1), .isl_ch2(isl_ch2),
    .word_out(word_out), .guard_err(guard_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [9:0] m_code(input logic [3:0] n);
    logic [9:0] t [16];
    t[0]  = 10'b1010011100; t[1]  = 10'b1001100011; t[2]  = 10'b1011100100;
    t[3]  = 10'b1011100010; t[4]  = 10'b0101110001; t[5]  = 10'b0100011110;
    t[6]  = 10'b0110001110; t[7]  = 10'b0100111100; t[8]  = 10'b1011001100;
    t[9]  = 10'b0100111001; t[10] = 10'b0110011100; t[11] = 10'b1011000110;
    t[12] = 10'b1010001110; t[13] = 10'b1001110001; t[14] = 10'b0101100011;
    t[15] = 10'b1011000011;
    return t[n];
  endfunction

  function automatic logic [9:0] m_ctl(input logic [1:0] c);
    logic [9:0] t [4];
    t[0] = 10'b1101010100; t[1] = 10'b0010101011;
    t[2] = 10'b0101010100; t[3] = 10'b1010101011;
    return t[c];
  endfunction

  function automatic logic [31:0] m_word(input logic [1:0] p, input logic vs, input logic hs,
                                         input logic [1:0] n0, input logic [3:0] n1,
                                         input logic [3:0] n2);
    logic [9:0] c0, c1, c2;
    case (p)
      2'd0: begin c0 = m_ctl({vs, hs}); c1 = m_ctl(2'b00); c2 = m_ctl(2'b00); end
      2'd1: begin c0 = m_ctl({vs, hs}); c1 = m_ctl(2'b01); c2 = m_ctl(2'b01); end
      2'd2: begin c0 = m_code({2'b11, vs, hs}); c1 = 10'b0100110011; c2 = 10'b0100110011; end
      default: begin c0 = m_code({n0, vs, hs}); c1 = m_code(n1); c2 = m_code(n2); end
    endcase
    return {2'b00, c2, c1, c0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic step(input logic [1:0] p, input logic vs, input logic hs,
                      input logic [1:0] n0, input logic [3:0] n1, input logic [3:0] n2);
    @(negedge clk);
    period = p; vsync = vs; hsync = hs; isl_ch0 = n0; isl_ch1 = n1; isl_ch2 = n2;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    period = 2'd3; vsync = 1'b1; hsync = 1'b1; isl_ch0 = 2'd3; isl_ch1 = 4'hF; isl_ch2 = 4'hA;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 word in reset", word_out, 32'h0);
    chk("R1 err in reset", {31'b0, guard_err}, 32'h0);
    @(negedge clk);
    period = 2'd0; vsync = 1'b0; hsync = 1'b0;
    rst_n = 1'b1;
    #1;
    chk("R1 word after release", word_out, 32'h0);
  endtask

  task automatic t_control;
    for (int s = 0; s < 4; s++) begin
      step(2'd0, s[1], s[0], 2'd0, 4'd0, 4'd0);
      chk("R2 control word", word_out, m_word(2'd0, s[1], s[0], 2'd0, 4'd0, 4'd0));
    end
    chk("R2 ch0 sync 11 literal", {22'b0, word_out[9:0]}, {22'b0, 10'b1010101011});
  endtask

  task automatic t_preamble;
    for (int s = 0; s < 4; s++) begin
      step(2'd1, s[1], s[0], 2'd0, 4'd0, 4'd0);
      chk("R3 preamble word", word_out, m_word(2'd1, s[1], s[0], 2'd0, 4'd0, 4'd0));
    end
  endtask

  task automatic t_guard;
    step(2'd0, 1'b0, 1'b1, 2'd0, 4'd0, 4'd0);
    step(2'd2, 1'b0, 1'b1, 2'd0, 4'd0, 4'd0);
    chk("R4 guard word", word_out, m_word(2'd2, 1'b0, 1'b1, 2'd0, 4'd0, 4'd0));
    chk("R4 guard ch0 literal", {22'b0, word_out[9:0]}, {22'b0, 10'b1001110001});
    chk("R8 steady guard no err", {31'b0, guard_err}, 32'h0);
  endtask

  task automatic t_data;
    for (int i = 0; i < 16; i++) begin
      logic [3:0] v;
      v = 4'(i);
      step(2'd3, v[1], v[0], v[3:2], v, ~v);
      chk("R5 data word", word_out, m_word(2'd3, v[1], v[0], v[3:2], v, ~v));
    end
    step(2'd3, 1'b0, 1'b0, 2'd0, 4'd0, 4'd15);
    chk("R6 code 0 and 15", word_out, {2'b00, 10'b1011000011, 10'b1010011100, 10'b1010011100});
  endtask

  task automatic t_pack;
    step(2'd3, 1'b1, 1'b0, 2'd2, 4'd5, 4'd9);
    chk("R7 ch0 field", {22'b0, word_out[9:0]}, {22'b0, m_code(4'b1010)});
    chk("R7 ch1 field", {22'b0, word_out[19:10]}, {22'b0, m_code(4'd5)});
    chk("R7 ch2 field", {22'b0, word_out[29:20]}, {22'b0, m_code(4'd9)});
    chk("R7 pad bits", {30'b0, word_out[31:30]}, 32'h0);
    @(negedge clk);
    period = 2'd0; vsync = 1'b0; hsync = 1'b0;
    chk("R7 no change before edge", word_out, m_word(2'd3, 1'b1, 1'b0, 2'd2, 4'd5, 4'd9));
    @(posedge clk);
    #1;
    chk("R7 update after one edge", word_out, m_word(2'd0, 1'b0, 1'b0, 2'd0, 4'd0, 4'd0));
  endtask

  task automatic t_guard_err;
    step(2'd0, 1'b0, 1'b0, 2'd0, 4'd0, 4'd0);
    step(2'd2, 1'b0, 1'b1, 2'd0, 4'd0, 4'd0);
    chk("R8 err on guard sync change", {31'b0, guard_err}, 32'h1);
    chk("R4 guard word in err cycle", word_out, m_word(2'd2, 1'b0, 1'b1, 2'd0, 4'd0, 4'd0));
    step(2'd2, 1'b0, 1'b1, 2'd0, 4'd0, 4'd0);
    chk("R8 err one cycle only", {31'b0, guard_err}, 32'h0);
    step(2'd3, 1'b1, 1'b1, 2'd1, 4'd2, 4'd3);
    chk("R8 data sync change no err", {31'b0, guard_err}, 32'h0);
    step(2'd0, 1'b1, 1'b0, 2'd0, 4'd0, 4'd0);
    chk("R8 control sync change no err", {31'b0, guard_err}, 32'h0);
    step(2'd2, 1'b0, 1'b0, 2'd0, 4'd0, 4'd0);
    chk("R8 vsync fall in guard", {31'b0, guard_err}, 32'h1);
  endtask

  task automatic t_ignored;
    step(2'd0, 1'b1, 1'b0, 2'd3, 4'hF, 4'h7);
    chk("R9 control ignores nibbles", word_out, m_word(2'd0, 1'b1, 1'b0, 2'd0, 4'd0, 4'd0));
    step(2'd1, 1'b1, 1'b0, 2'd2, 4'h9, 4'h1);
    chk("R9 preamble ignores nibbles", word_out, m_word(2'd1, 1'b1, 1'b0, 2'd0, 4'd0, 4'd0));
    step(2'd2, 1'b1, 1'b0, 2'd1, 4'hC, 4'h4);
    chk("R9 guard ignores nibbles", word_out, m_word(2'd2, 1'b1, 1'b0, 2'd0, 4'd0, 4'd0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_control();
    t_preamble();
    t_guard();
    t_data();
    t_pack();
    t_guard_err();
    t_ignored();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule